// File: doc/BRIEF.md
# Directory-Coherent Cache Line Controller

This block is the cache-side agent of a directory-based coherence scheme. Each direct-mapped line holds one of three states: Invalid, Shared (read-only copy) or Exclusive (the only valid copy, writable). The processor presents one access at a time. Hits finish in the same cycle. A miss becomes an explicit point-to-point message to the home directory, and the processor stays stalled until the directory's data reply arrives.

The home directory can also send messages to this agent. It may drop a shared copy, ask for the data of an owned line (the line then stays readable here), or ask for that data and take the line away. In both data-request cases the agent answers with a write-back message that carries the line's address and contents. An owned line that is displaced by a miss to another address is written back before the miss message goes out. A shared line is dropped silently. Outgoing messages appear on a registered port one cycle after the decision, and every one carries this node's number.

Top module: `dirCacheCtrl`

## Requirements
- R1: A processor read whose line is Invalid or holds another tag sends a read-miss message (type 0, this node, the full address, data 0). When the reply comes, the line becomes Shared and holds the reply data.
- R2: A processor write to a line that is not Exclusive with a matching tag sends a write-miss message (type 1). This includes a write to a Shared line. When the reply comes, the line becomes Exclusive and holds the processor's write data.
- R3: An incoming invalidate (type 0) to a Shared line with a matching tag makes the line Invalid. An invalidate to an Exclusive line, or to a line holding another tag, changes nothing.
- R4: An incoming fetch (type 1) to an Exclusive line with a matching tag sends a write-back message (type 2) carrying that address and the line's data, and the line becomes Shared. In every other case the fetch is ignored.
- R5: An incoming fetch-and-invalidate (type 2) to an Exclusive line with a matching tag sends the same write-back, and the line becomes Invalid.
- R6: A miss that displaces an Exclusive line holding another tag first sends a write-back of the old address and data. The miss message follows in the next cycle unless an incoming coherence message takes that cycle.
- R7: After a miss, the processor is stalled until a data reply (incoming type 3) arrives. The access completes in the reply cycle, and a read returns the reply data in that same cycle.
- R8: Reads of Shared or Exclusive lines and writes to Exclusive lines with matching tags complete in the request cycle and send no message. A write hit updates the stored data.
- R9: Incoming invalidate, fetch and fetch-and-invalidate messages are handled while a miss is outstanding. An incoming coherence message takes priority over the processor in its cycle, and the processor stays stalled during that cycle.
- R10: After reset every line is Invalid, no message is sent and no access completes. An outgoing message is valid for exactly the one cycle that follows its decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access request, held until done |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Access address (low bits index the line) |
| cpuWdata | input | DATA_W | Write data |
| cpuDone | output | 1 | Access completes this cycle |
| cpuStall | output | 1 | Request present and not completing |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone on a read |
| msgInValid | input | 1 | Incoming message present |
| msgInType | input | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msgInAddr | input | ADDR_W | Incoming message address |
| msgInData | input | DATA_W | Reply data |
| msgOutValid | output | 1 | Outgoing message present |
| msgOutType | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| msgOutNode | output | NODE_W | This node's number |
| msgOutAddr | output | ADDR_W | Outgoing message address |
| msgOutData | output | DATA_W | Write-back data, 0 for misses |

## Verification
The miss path is driven from each starting state: Invalid, Shared with the same tag (an upgrade), and Exclusive with another tag (a displacement). This separates silent replacement from write-back-then-miss ordering and read misses from write misses. Coherence messages are aimed at matching Shared lines, matching Exclusive lines, non-matching tags and lines that are still waiting for a reply. This shows which line states each message may change. Replies arrive after different delays, and coherence messages are injected in the middle of a wait or in the same cycle as a hitting request. These cases check the stall length and the arbitration priority.

// File: rtl/dirPkg.sv
package dirPkg;
  typedef enum logic [1:0] {LS_INV = 2'd0, LS_SHR = 2'd1, LS_EXC = 2'd2} lineState_t;
  typedef enum logic [1:0] {C_IDLE = 2'd0, C_SENDMISS = 2'd1, C_WAIT = 2'd2} ctrlState_t;
  typedef enum logic [1:0] {AS_CPU = 2'd0, AS_VICTIM = 2'd1, AS_INMSG = 2'd2} addrSel_t;

  localparam logic [1:0] OUT_RDMISS  = 2'd0;
  localparam logic [1:0] OUT_WRMISS  = 2'd1;
  localparam logic [1:0] OUT_WRBACK  = 2'd2;

  localparam logic [1:0] IN_INVAL    = 2'd0;
  localparam logic [1:0] IN_FETCH    = 2'd1;
  localparam logic [1:0] IN_FETCHINV = 2'd2;
  localparam logic [1:0] IN_REPLY    = 2'd3;

  typedef struct packed {
    logic       lineSelIn;
    logic       stWe;
    lineState_t stVal;
    logic       tagWe;
    logic       dataWe;
    logic       dataFromReply;
    logic       msgSend;
    logic [1:0] msgType;
    addrSel_t   addrSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/dirLineStore.sv
module dirLineStore
  import dirPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int LINES   = 8,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] msgInAddr,
  input  logic [DATA_W-1:0] msgInData,
  output lineState_t        cpuLineState,
  output logic              cpuTagHit,
  output logic [DATA_W-1:0] cpuLineData,
  output lineState_t        inLineState,
  output logic              inTagHit,
  output logic              msgOutValid,
  output logic [1:0]        msgOutType,
  output logic [NODE_W-1:0] msgOutNode,
  output logic [ADDR_W-1:0] msgOutAddr,
  output logic [DATA_W-1:0] msgOutData
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_t        stArr   [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  logic [IDX_W-1:0] cpuIdx, inIdx, wrIdx;
  logic [TAG_W-1:0] cpuTag, inTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign inIdx  = msgInAddr[IDX_W-1:0];
  assign inTag  = msgInAddr[ADDR_W-1:IDX_W];
  assign wrIdx  = strobe.lineSelIn ? inIdx : cpuIdx;

  assign cpuLineState = stArr[cpuIdx];
  assign cpuTagHit    = (tagArr[cpuIdx] == cpuTag);
  assign cpuLineData  = dataArr[cpuIdx];
  assign inLineState  = stArr[inIdx];
  assign inTagHit     = (tagArr[inIdx] == inTag);
  assign msgOutNode   = NODE_W'(NODE_ID);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) stArr[i] <= LS_INV;
    end else if (strobe.stWe) begin
      stArr[wrIdx] <= strobe.stVal;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.tagWe) tagArr[cpuIdx] <= cpuTag;
    if (strobe.dataWe) dataArr[cpuIdx] <= strobe.dataFromReply ? msgInData : cpuWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgOutValid <= 1'b0;
      msgOutType  <= '0;
      msgOutAddr  <= '0;
      msgOutData  <= '0;
    end else if (strobe.msgSend) begin
      msgOutValid <= 1'b1;
      msgOutType  <= strobe.msgType;
      case (strobe.addrSel)
        AS_VICTIM: msgOutAddr <= {tagArr[cpuIdx], cpuIdx};
        AS_INMSG:  msgOutAddr <= msgInAddr;
        default:   msgOutAddr <= cpuAddr;
      endcase
      if (strobe.msgType != OUT_WRBACK) msgOutData <= '0;
      else if (strobe.addrSel == AS_INMSG) msgOutData <= dataArr[inIdx];
      else msgOutData <= dataArr[cpuIdx];
    end else begin
      msgOutValid <= 1'b0;
      msgOutType  <= '0;
      msgOutAddr  <= '0;
      msgOutData  <= '0;
    end
  end
endmodule

// File: rtl/dirCtrlFsm.sv
module dirCtrlFsm
  import dirPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        msgInValid,
  input  logic [1:0]  msgInType,
  input  lineState_t  cpuLineState,
  input  logic        cpuTagHit,
  input  lineState_t  inLineState,
  input  logic        inTagHit,
  output ctrlStrobe_t strobe,
  output logic        cpuDone,
  output logic        rdFromReply
);
  ctrlState_t curState, nextState;
  logic cohIn, inMatch, cpuMatch;

  assign cohIn    = msgInValid && (msgInType != IN_REPLY);
  assign inMatch  = (inLineState != LS_INV) && inTagHit;
  assign cpuMatch = (cpuLineState != LS_INV) && cpuTagHit;
  assign rdFromReply = (curState == C_WAIT);

  always_comb begin
    strobe    = '0;
    cpuDone   = 1'b0;
    nextState = curState;
    if (cohIn) begin
      strobe.lineSelIn = 1'b1;
      strobe.addrSel   = AS_INMSG;
      strobe.msgType   = OUT_WRBACK;
      case (msgInType)
        IN_INVAL: if (inMatch && inLineState == LS_SHR) begin
          strobe.stWe  = 1'b1;
          strobe.stVal = LS_INV;
        end
        IN_FETCH: if (inMatch && inLineState == LS_EXC) begin
          strobe.stWe    = 1'b1;
          strobe.stVal   = LS_SHR;
          strobe.msgSend = 1'b1;
        end
        IN_FETCHINV: if (inMatch && inLineState == LS_EXC) begin
          strobe.stWe    = 1'b1;
          strobe.stVal   = LS_INV;
          strobe.msgSend = 1'b1;
        end
        default: ;
      endcase
    end else begin
      case (curState)
        C_IDLE: if (cpuReq) begin
          if (!cpuWe && cpuMatch) begin
            cpuDone = 1'b1;
          end else if (cpuWe && cpuMatch && cpuLineState == LS_EXC) begin
            cpuDone       = 1'b1;
            strobe.dataWe = 1'b1;
          end else begin
            strobe.stWe    = 1'b1;
            strobe.stVal   = LS_INV;
            strobe.tagWe   = 1'b1;
            strobe.msgSend = 1'b1;
            if (cpuLineState == LS_EXC && !cpuTagHit) begin
              strobe.msgType = OUT_WRBACK;
              strobe.addrSel = AS_VICTIM;
              nextState      = C_SENDMISS;
            end else begin
              strobe.msgType = cpuWe ? OUT_WRMISS : OUT_RDMISS;
              strobe.addrSel = AS_CPU;
              nextState      = C_WAIT;
            end
          end
        end
        C_SENDMISS: begin
          strobe.msgSend = 1'b1;
          strobe.msgType = cpuWe ? OUT_WRMISS : OUT_RDMISS;
          strobe.addrSel = AS_CPU;
          nextState      = C_WAIT;
        end
        C_WAIT: if (msgInValid && msgInType == IN_REPLY) begin
          cpuDone              = 1'b1;
          strobe.stWe          = 1'b1;
          strobe.stVal         = cpuWe ? LS_EXC : LS_SHR;
          strobe.dataWe        = 1'b1;
          strobe.dataFromReply = !cpuWe;
          nextState            = C_IDLE;
        end
        default: nextState = C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= C_IDLE;
    else curState <= nextState;
  end
endmodule

// File: rtl/dirCacheCtrl.sv
module dirCacheCtrl
  import dirPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int LINES   = 8,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic              cpuStall,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              msgInValid,
  input  logic [1:0]        msgInType,
  input  logic [ADDR_W-1:0] msgInAddr,
  input  logic [DATA_W-1:0] msgInData,
  output logic              msgOutValid,
  output logic [1:0]        msgOutType,
  output logic [NODE_W-1:0] msgOutNode,
  output logic [ADDR_W-1:0] msgOutAddr,
  output logic [DATA_W-1:0] msgOutData
);
  ctrlStrobe_t       strobe;
  lineState_t        cpuLineState, inLineState;
  logic              cpuTagHit, inTagHit, rdFromReply;
  logic [DATA_W-1:0] cpuLineData;

  dirCtrlFsm ctrl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .msgInValid(msgInValid), .msgInType(msgInType),
    .cpuLineState(cpuLineState), .cpuTagHit(cpuTagHit),
    .inLineState(inLineState), .inTagHit(inTagHit),
    .strobe(strobe), .cpuDone(cpuDone), .rdFromReply(rdFromReply)
  );

  dirLineStore #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES),
    .NODE_W(NODE_W), .NODE_ID(NODE_ID)
  ) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .msgInAddr(msgInAddr), .msgInData(msgInData),
    .cpuLineState(cpuLineState), .cpuTagHit(cpuTagHit), .cpuLineData(cpuLineData),
    .inLineState(inLineState), .inTagHit(inTagHit),
    .msgOutValid(msgOutValid), .msgOutType(msgOutType), .msgOutNode(msgOutNode),
    .msgOutAddr(msgOutAddr), .msgOutData(msgOutData)
  );

  assign cpuStall = cpuReq && !cpuDone;
  assign cpuRdata = rdFromReply ? msgInData : cpuLineData;
endmodule

// File: rtl/dirCacheCtrlChk.sv
module dirCacheCtrlChk
  import dirPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cpuReq,
  input logic       cpuWe,
  input logic       cpuDone,
  input logic       msgInValid,
  input logic [1:0] msgInType,
  input logic       msgOutValid,
  input logic [1:0] msgOutType
);
  logic cohNow, replyNow;
  assign cohNow   = msgInValid && (msgInType != IN_REPLY);
  assign replyNow = msgInValid && (msgInType == IN_REPLY);

  // R1: a read-miss message follows only a pending processor read
  a_r1_rdmiss_from_read: assert property (@(posedge clk) disable iff (!rstN)
    (msgOutValid && msgOutType == OUT_RDMISS) |-> $past(cpuReq && !cpuWe));

  // R2: a write-miss message follows only a pending processor write
  a_r2_wrmiss_from_write: assert property (@(posedge clk) disable iff (!rstN)
    (msgOutValid && msgOutType == OUT_WRMISS) |-> $past(cpuReq && cpuWe));

  // R6: a displacement write-back is followed by the miss message
  a_r6_wb_then_miss: assert property (@(posedge clk) disable iff (!rstN)
    (msgOutValid && msgOutType == OUT_WRBACK && !cohNow && $past(!cohNow))
      |=> (msgOutValid && msgOutType != OUT_WRBACK));

  // R7: no completion while a miss is out and no reply has come
  a_r7_stall_until_reply: assert property (@(posedge clk) disable iff (!rstN)
    (msgOutValid && msgOutType != OUT_WRBACK && !replyNow) |-> !cpuDone);

  // R8: completion only for a present request
  a_r8_done_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> cpuReq);

  // R9: a coherence message holds off the processor in its cycle
  a_r9_coh_priority: assert property (@(posedge clk) disable iff (!rstN)
    cohNow |-> !cpuDone);
endmodule

bind dirCacheCtrl dirCacheCtrlChk chk_i (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuDone(cpuDone),
  .msgInValid(msgInValid), .msgInType(msgInType),
  .msgOutValid(msgOutValid), .msgOutType(msgOutType)
);

// File: tb/dirCacheCtrl_tb.sv
module dirCacheCtrl_tb_top;
  localparam int NODE = 2;

  logic clk = 0;
  logic rstN = 0;
  logic cpuReq = 0, cpuWe = 0;
  logic [7:0] cpuAddr = 0, cpuWdata = 0;
  logic cpuDone, cpuStall;
  logic [7:0] cpuRdata;
  logic msgInValid = 0;
  logic [1:0] msgInType = 0;
  logic [7:0] msgInAddr = 0, msgInData = 0;
  logic msgOutValid;
  logic [1:0] msgOutType, msgOutNode;
  logic [7:0] msgOutAddr, msgOutData;

  always #2 clk = ~clk;

  dirCacheCtrl #(.ADDR_W(8), .DATA_W(8), .LINES(8), .NODE_W(2), .NODE_ID(NODE)) dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuStall(cpuStall), .cpuRdata(cpuRdata),
    .msgInValid(msgInValid), .msgInType(msgInType), .msgInAddr(msgInAddr),
    .msgInData(msgInData), .msgOutValid(msgOutValid), .msgOutType(msgOutType),
    .msgOutNode(msgOutNode), .msgOutAddr(msgOutAddr), .msgOutData(msgOutData)
  );

  int checks = 0, fails = 0, cycCnt = 0;
  string tagReq = "R10";

  // behavioural reference: 0 invalid, 1 shared, 2 exclusive
  int mSt[8], mTag[8], mData[8];
  int mCtl = 0, waitCnt = 0;
  int mOutV = 0, mOutT = 0, mOutA = 0, mOutD = 0;
  int lastDone = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tagReq, what, act, exp);
    end
  endtask

  task automatic checkAndStep();
    int eDone = 0, eRd = 0, nV = 0, nT = 0, nA = 0, nD = 0, nCtl = mCtl;
    int i, t;
    bit coh = msgInValid && msgInType != 3;
    if (coh) begin
      i = msgInAddr % 8; t = msgInAddr / 8;
      if (mSt[i] != 0 && mTag[i] == t) begin
        if (msgInType == 0 && mSt[i] == 1) mSt[i] = 0;
        else if (msgInType != 0 && mSt[i] == 2) begin
          nV = 1; nT = 2; nA = msgInAddr; nD = mData[i];
          mSt[i] = (msgInType == 1) ? 1 : 0;
        end
      end
    end else if (mCtl == 0 && cpuReq) begin
      i = cpuAddr % 8; t = cpuAddr / 8;
      if (!cpuWe && mSt[i] != 0 && mTag[i] == t) begin
        eDone = 1; eRd = mData[i];
      end else if (cpuWe && mSt[i] == 2 && mTag[i] == t) begin
        eDone = 1; mData[i] = cpuWdata;
      end else begin
        nV = 1;
        if (mSt[i] == 2 && mTag[i] != t) begin
          nT = 2; nA = mTag[i] * 8 + i; nD = mData[i]; nCtl = 1;
        end else begin
          nT = cpuWe ? 1 : 0; nA = cpuAddr; nCtl = 2;
        end
        mSt[i] = 0; mTag[i] = t;
      end
    end else if (mCtl == 1) begin
      nV = 1; nT = cpuWe ? 1 : 0; nA = cpuAddr; nCtl = 2;
    end else if (mCtl == 2 && msgInValid && msgInType == 3) begin
      i = cpuAddr % 8;
      eDone = 1; eRd = msgInData;
      mSt[i] = cpuWe ? 2 : 1;
      mData[i] = cpuWe ? cpuWdata : msgInData;
      nCtl = 0;
    end
    chk("cpuDone", cpuDone, eDone);
    chk("cpuStall", cpuStall, (cpuReq && !eDone) ? 1 : 0);
    if (eDone && !cpuWe) chk("cpuRdata", cpuRdata, eRd);
    chk("msgOutValid", msgOutValid, mOutV);
    if (mOutV) begin
      chk("msgOutType", msgOutType, mOutT);
      chk("msgOutNode", msgOutNode, NODE);
      chk("msgOutAddr", msgOutAddr, mOutA);
      chk("msgOutData", msgOutData, mOutD);
    end
    lastDone = eDone;
    mOutV = nV; mOutT = nT; mOutA = nA; mOutD = nD; mCtl = nCtl;
  endtask

  task automatic cyc(bit rq, bit we, int a, int wd, bit iv, int it, int ia, int id);
    @(negedge clk);
    cpuReq = rq; cpuWe = we; cpuAddr = 8'(a); cpuWdata = 8'(wd);
    msgInValid = iv; msgInType = 2'(it); msgInAddr = 8'(ia); msgInData = 8'(id);
    #1 checkAndStep();
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic coh(int it, int ia);
    cyc(0, 0, 0, 0, 1, it, ia, 0);
    idle();
  endtask

  // holds the request until done; reply after dly waiting cycles; optional injection
  task automatic access(bit we, int a, int wd, int dly, int rd, int injT, int injA, int injAt);
    waitCnt = 0;
    for (int k = 0; k < 60; k++) begin
      if (mCtl == 2 && waitCnt == injAt)
        cyc(1, we, a, wd, 1, injT, injA, 0);
      else if (mCtl == 2 && waitCnt >= dly)
        cyc(1, we, a, wd, 1, 3, 0, rd);
      else
        cyc(1, we, a, wd, 0, 0, 0, 0);
      if (lastDone) break;
      if (mCtl == 2) waitCnt++;
    end
    chk("access completed", lastDone, 1);
    idle();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mSt[i] = 0; mTag[i] = 0; mData[i] = 0; end
    repeat (3) @(negedge clk);
    tagReq = "R10";
    chk("reset msgOutValid", msgOutValid, 0);
    chk("reset cpuDone", cpuDone, 0);
    @(negedge clk); rstN = 1;
    idle(); idle();
    // reset leaves all lines invalid: a read must miss
    tagReq = "R1";  access(0, 8'h11, 0, 2, 8'hA5, 0, 0, -1);
    tagReq = "R8";  access(0, 8'h11, 0, 0, 0, 0, 0, -1);
    tagReq = "R2";  access(1, 8'h22, 8'h3C, 1, 8'h00, 0, 0, -1);
    tagReq = "R8";  access(1, 8'h22, 8'h77, 0, 0, 0, 0, -1);
    access(0, 8'h22, 0, 0, 0, 0, 0, -1);
    tagReq = "R2";  access(1, 8'h11, 8'h5A, 3, 8'h99, 0, 0, -1);
    tagReq = "R4";  coh(1, 8'h22);
    coh(1, 8'h2A);               // other tag: ignored
    access(0, 8'h22, 0, 0, 0, 0, 0, -1);
    tagReq = "R3";  coh(0, 8'h11); // exclusive: ignored
    access(0, 8'h11, 0, 0, 0, 0, 0, -1);
    coh(0, 8'h22);
    access(0, 8'h22, 0, 1, 8'h44, 0, 0, -1);
    tagReq = "R5";  coh(2, 8'h11);
    access(0, 8'h11, 0, 1, 8'h12, 0, 0, -1);
    tagReq = "R6";  access(1, 8'h0B, 8'h61, 1, 0, 0, 0, -1);
    access(1, 8'h13, 8'h62, 2, 0, 0, 0, -1);
    access(0, 8'h1B, 0, 1, 8'h63, 0, 0, -1);
    tagReq = "R9";  access(1, 8'h35, 8'h70, 1, 0, 0, 0, -1);
    access(0, 8'h2C, 0, 3, 8'h71, 2, 8'h35, 1);
    access(0, 8'h35, 0, 1, 8'h72, 0, 0, -1);
    cyc(1, 0, 8'h1B, 0, 1, 0, 8'h2C, 0); // coherence wins over a hitting read
    access(0, 8'h1B, 0, 0, 0, 0, 0, -1);
    access(0, 8'h2C, 0, 2, 8'h73, 0, 0, -1);
    tagReq = "R7";  access(0, 8'h06, 0, 6, 8'hE1, 0, 0, -1);
    access(1, 8'h0E, 8'hE2, 0, 0, 0, 0, -1);
    access(1, 8'h16, 8'hE3, 4, 0, 1, 8'h0E, 2);
    idle(); idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycCnt, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule